// File: doc/BRIEF.md
# Shadow Memory Segment Attribute Decoder

This block turns a small set of configuration bits into routing attributes for the 256 KB upper memory window. The window is split into eight 32 KB segments, and segment i starts at 0xC0000 + i*0x8000. For each segment the block decides two things. First, whether reads and writes are served by internal DRAM or passed to the external bus. Second, when an access goes external, whether it is an ordinary external cycle or one that also asserts the ROM chip select.

The attributes computed on each cycle are compared with the copy held per segment. A segment whose attributes differ from its stored copy loads the new value and raises a one-cycle update strobe. A force-flush input reloads every segment, strobes all of them and emits a single flush pulse. When either of the two segments at 0xF0000 and above stops reading from internal memory, the block raises an invalidate request so that a neighbouring cache can drop stale lines. Status outputs report which segments are shadowed and whether any segment in the 0xE0000–0xFFFFF range reads or writes internal memory.

All outputs are registered and change one clock after the inputs they depend on. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `shadow_seg_decoder`

## Requirements
- R1: Segments 6 and 7 are always under shadow control. Segment i in 0..5 is under shadow control only while `shadow_en[i]` is 1.
- R2: In a controlled segment, reads use internal memory when `shadow_en[7]` is 1, and writes use internal memory when `shadow_en[6]` is 0.
- R3: In a segment that is not controlled, both reads and writes go to the external bus (both internal bits are 0).
- R4: The ROM select mask always contains segments 6 and 7. `cfg_a[6]` adds segment 0, `cfg_a[7]` adds segments 4 and 5, and `cfg_b[2]` adds segment 1. An external read or write in a masked segment has its ROM bit set. Any other external access, and every internal access, has its ROM bit clear. Each segment has a 4-bit field in `seg_attr` at bits [4i+3:4i], laid out as {wr_rom, wr_int, rd_rom, rd_int} from bit 3 down to bit 0.
- R5: `shadowed[i]` is 1 exactly when segment i has internal read or internal write set.
- R6: `upd_strobe[i]` is 1 for one cycle after segment i's attributes change. It is 0 while the attributes stay the same.
- R7: Force-flush raises every bit of `upd_strobe` and `flush_pulse` for exactly one cycle, even when no attribute changes.
- R8: `inval_req` is 1 for one cycle when segment 6 or segment 7 goes from internal read to external read.
- R9: `bios_rd_int` is the OR of internal read over segments 4..7. `bios_wr_int` is the same OR over internal write.
- R10: While reset is asserted, all stored attributes, strobes, the flush pulse and the invalidate request are 0.
- R11: Outputs change one clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shadow_en | input | 8 | Per-segment control enables in bits 5..0; bit 7 selects internal read, bit 6 blocks internal write |
| cfg_a | input | 8 | Configuration byte A; bits 6 and 7 extend the ROM mask |
| cfg_b | input | 8 | Configuration byte B; bit 2 extends the ROM mask |
| force_flush | input | 1 | One-cycle request to reload and strobe every segment |
| seg_attr | output | 32 | Stored attributes, 4 bits per segment |
| shadowed | output | 8 | Per-segment shadowed flag |
| upd_strobe | output | 8 | Per-segment update strobe |
| flush_pulse | output | 1 | Global flush pulse |
| inval_req | output | 1 | Invalidate request for the top segments |
| bios_rd_int | output | 1 | Some segment in 4..7 reads internal memory |
| bios_wr_int | output | 1 | Some segment in 4..7 writes internal memory |

## Verification
The assertions check on every cycle the relations that hold between stored state and inputs. A strobe without a flush always follows an attribute change. A flush strobes every segment. The top segments follow the read and write selects one cycle later. An uncontrolled segment is never internal. An invalidate request always matches a lost internal read on segment 6 or 7. Only the bench's scenarios can show the exact ROM-mask mapping for each configuration bit, that the strobe sets cover exactly the changed segments, that the BIOS range status is correct, and that re-applying the same settings produces no strobe.

// File: rtl/shseg_pkg.sv
package shseg_pkg;
  typedef struct packed {
    logic wr_rom;
    logic wr_int;
    logic rd_rom;
    logic rd_int;
  } seg_attr_t;

  localparam int ATTR_W = 4;
endpackage

// File: rtl/shseg_rom_mask.sv
module shseg_rom_mask #(
  parameter int          NSEG      = 8,
  parameter logic [NSEG-1:0] BASE_MASK = 8'hC0,
  parameter logic [NSEG-1:0] A6_SEGS   = 8'h01,
  parameter logic [NSEG-1:0] A7_SEGS   = 8'h30,
  parameter logic [NSEG-1:0] B2_SEGS   = 8'h02
) (
  input  logic [7:0]      cfg_a,
  input  logic [7:0]      cfg_b,
  output logic [NSEG-1:0] rom_mask
);
  always_comb begin
    rom_mask = BASE_MASK;
    if (cfg_a[6]) rom_mask = rom_mask | A6_SEGS;
    if (cfg_a[7]) rom_mask = rom_mask | A7_SEGS;
    if (cfg_b[2]) rom_mask = rom_mask | B2_SEGS;
  end
endmodule

// File: rtl/shseg_attr_decode.sv
module shseg_attr_decode
  import shseg_pkg::*;
#(
  parameter int          NSEG        = 8,
  parameter logic [NSEG-1:0] ALWAYS_CTRL = 8'hC0,
  parameter int          RD_SEL_BIT  = 7,
  parameter int          WR_OFF_BIT  = 6
) (
  input  logic [7:0]      shadow_en,
  input  logic [NSEG-1:0] rom_mask,
  output seg_attr_t       attr_nxt [NSEG]
);
  logic rd_sel;
  logic wr_sel;

  assign rd_sel = shadow_en[RD_SEL_BIT];
  assign wr_sel = ~shadow_en[WR_OFF_BIT];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic ctrl;
    if (ALWAYS_CTRL[i]) begin : g_fixed
      assign ctrl = 1'b1;
    end else begin : g_sel
      assign ctrl = shadow_en[i];
    end

    always_comb begin
      attr_nxt[i].rd_int = ctrl & rd_sel;
      attr_nxt[i].wr_int = ctrl & wr_sel;
      attr_nxt[i].rd_rom = ~attr_nxt[i].rd_int & rom_mask[i];
      attr_nxt[i].wr_rom = ~attr_nxt[i].wr_int & rom_mask[i];
    end
  end
endmodule

// File: rtl/shseg_state.sv
module shseg_state
  import shseg_pkg::*;
#(
  parameter int NSEG     = 8,
  parameter int INV_LO   = 6,
  parameter int BIOS_LO  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  seg_attr_t      attr_nxt [NSEG],
  input  logic           force_flush,
  output seg_attr_t      attr_q [NSEG],
  output logic [NSEG-1:0] strobe_q,
  output logic           flush_q,
  output logic           inval_q,
  output logic           bios_rd_q,
  output logic           bios_wr_q
);
  logic [NSEG-1:0] seg_load;
  logic [NSEG-1:0] rd_lost;
  logic            inval_d;
  logic            bios_rd_d;
  logic            bios_wr_d;

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      seg_load[i] = force_flush | (attr_nxt[i] != attr_q[i]);
      rd_lost[i]  = (i >= INV_LO) & attr_q[i].rd_int & ~attr_nxt[i].rd_int;
    end
    inval_d   = |rd_lost;
    bios_rd_d = 1'b0;
    bios_wr_d = 1'b0;
    for (int i = BIOS_LO; i < NSEG; i++) begin
      bios_rd_d = bios_rd_d | attr_nxt[i].rd_int;
      bios_wr_d = bios_wr_d | attr_nxt[i].wr_int;
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attr_q[i] <= '0;
      end else if (seg_load[i]) begin
        attr_q[i] <= attr_nxt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= '0;
      flush_q   <= 1'b0;
      inval_q   <= 1'b0;
      bios_rd_q <= 1'b0;
      bios_wr_q <= 1'b0;
    end else begin
      strobe_q  <= seg_load;
      flush_q   <= force_flush;
      inval_q   <= inval_d;
      bios_rd_q <= bios_rd_d;
      bios_wr_q <= bios_wr_d;
    end
  end
endmodule

// File: rtl/shadow_seg_decoder.sv
module shadow_seg_decoder
  import shseg_pkg::*;
#(
  parameter int NSEG = 8,
  localparam int AW  = NSEG * ATTR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      shadow_en,
  input  logic [7:0]      cfg_a,
  input  logic [7:0]      cfg_b,
  input  logic            force_flush,
  output logic [AW-1:0]   seg_attr,
  output logic [NSEG-1:0] shadowed,
  output logic [NSEG-1:0] upd_strobe,
  output logic            flush_pulse,
  output logic            inval_req,
  output logic            bios_rd_int,
  output logic            bios_wr_int
);
  logic [1:0]      rst_sync_q;
  logic            rst_sync_n;
  logic [NSEG-1:0] rom_mask;
  seg_attr_t       attr_nxt [NSEG];
  seg_attr_t       attr_q   [NSEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  shseg_rom_mask #(.NSEG(NSEG)) u_mask (
    .cfg_a    (cfg_a),
    .cfg_b    (cfg_b),
    .rom_mask (rom_mask)
  );

  shseg_attr_decode #(.NSEG(NSEG)) u_dec (
    .shadow_en (shadow_en),
    .rom_mask  (rom_mask),
    .attr_nxt  (attr_nxt)
  );

  shseg_state #(.NSEG(NSEG)) u_state (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .attr_nxt    (attr_nxt),
    .force_flush (force_flush),
    .attr_q      (attr_q),
    .strobe_q    (upd_strobe),
    .flush_q     (flush_pulse),
    .inval_q     (inval_req),
    .bios_rd_q   (bios_rd_int),
    .bios_wr_q   (bios_wr_int)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_out
    assign seg_attr[i*ATTR_W +: ATTR_W] = attr_q[i];
    assign shadowed[i] = attr_q[i].rd_int | attr_q[i].wr_int;
  end
endmodule

// File: rtl/shadow_seg_decoder_chk.sv
module shadow_seg_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  shadow_en,
  input logic        force_flush,
  input logic [31:0] seg_attr,
  input logic [7:0]  upd_strobe,
  input logic        flush_pulse,
  input logic        inval_req
);
  AST_STROBE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe != 8'h00 && !flush_pulse) |-> (seg_attr != $past(seg_attr))); // R6

  AST_FLUSH_ALL_SEGS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> (upd_strobe == 8'hFF)); // R7

  AST_FLUSH_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    force_flush |=> flush_pulse); // R7

  AST_TOP_READ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_en[7] |=> (seg_attr[28] && seg_attr[24])); // R2

  AST_TOP_WRITE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_en[6] |=> (seg_attr[30] && seg_attr[26])); // R1

  AST_UNCTRL_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_en[0] |=> (!seg_attr[0] && !seg_attr[2])); // R3

  AST_INVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    inval_req |-> (($past(seg_attr[24]) && !seg_attr[24]) ||
                   ($past(seg_attr[28]) && !seg_attr[28]))); // R8
endmodule

bind shadow_seg_decoder shadow_seg_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .shadow_en   (shadow_en),
  .force_flush (force_flush),
  .seg_attr    (seg_attr),
  .upd_strobe  (upd_strobe),
  .flush_pulse (flush_pulse),
  .inval_req   (inval_req)
);

// File: tb/shadow_seg_decoder_bench.sv
module shadow_seg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  shadow_en;
  logic [7:0]  cfg_a;
  logic [7:0]  cfg_b;
  logic        force_flush;
  logic [31:0] seg_attr;
  logic [7:0]  shadowed;
  logic [7:0]  upd_strobe;
  logic        flush_pulse;
  logic        inval_req;
  logic        bios_rd_int;
  logic        bios_wr_int;

  int checks = 0;
  int fails  = 0;
  logic [31:0] prev_attr;

  always #4 clk = ~clk;

  shadow_seg_decoder u_shadow_seg_decoder (
    .clk(clk), .rst_n(rst_n), .shadow_en(shadow_en), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .force_flush(force_flush), .seg_attr(seg_attr), .shadowed(shadowed),
    .upd_strobe(upd_strobe), .flush_pulse(flush_pulse), .inval_req(inval_req),
    .bios_rd_int(bios_rd_int), .bios_wr_int(bios_wr_int)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected attribute vector, built from the requirements
  function automatic logic [31:0] model(input logic [7:0] sh, input logic [7:0] a,
                                        input logic [7:0] b);
    logic [7:0]  mask;
    logic [31:0] r;
    mask = 8'hC0;
    if (a[6]) mask[0] = 1'b1;
    if (a[7]) mask[5:4] = 2'b11;
    if (b[2]) mask[1] = 1'b1;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      logic c, ri, wi;
      c  = (i >= 6) ? 1'b1 : sh[i];
      ri = c & sh[7];
      wi = c & ~sh[6];
      r[4*i+0] = ri;
      r[4*i+1] = ~ri & mask[i];
      r[4*i+2] = wi;
      r[4*i+3] = ~wi & mask[i];
    end
    return r;
  endfunction

  // Drive at a falling edge, sample at the next falling edge (one rising edge between)
  task automatic step(input logic [7:0] sh, input logic [7:0] a, input logic [7:0] b,
                      input logic ff);
    logic [31:0] exp;
    logic [7:0]  exp_str, exp_sh;
    logic        exp_inv, exp_brd, exp_bwr;
    @(negedge clk);
    shadow_en = sh; cfg_a = a; cfg_b = b; force_flush = ff;
    @(negedge clk);
    force_flush = 1'b0;
    exp = model(sh, a, b);
    for (int i = 0; i < 8; i++) begin
      exp_str[i] = ff | (exp[4*i +: 4] != prev_attr[4*i +: 4]);
      exp_sh[i]  = exp[4*i] | exp[4*i+2];
    end
    exp_inv = (prev_attr[24] & ~exp[24]) | (prev_attr[28] & ~exp[28]);
    exp_brd = exp[16] | exp[20] | exp[24] | exp[28];
    exp_bwr = exp[18] | exp[22] | exp[26] | exp[30];
    check(seg_attr === exp, "R1/R2/R3/R4 R11 seg_attr", seg_attr, exp);
    check(shadowed === exp_sh, "R5 shadowed", {24'h0, shadowed}, {24'h0, exp_sh});
    check(upd_strobe === exp_str, "R6 upd_strobe", {24'h0, upd_strobe}, {24'h0, exp_str});
    check(flush_pulse === ff, "R7 flush_pulse", {31'h0, flush_pulse}, {31'h0, ff});
    check(inval_req === exp_inv, "R8 inval_req", {31'h0, inval_req}, {31'h0, exp_inv});
    check({bios_rd_int, bios_wr_int} === {exp_brd, exp_bwr}, "R9 bios status",
          {30'h0, bios_rd_int, bios_wr_int}, {30'h0, exp_brd, exp_bwr});
    prev_attr = exp;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; shadow_en = 8'h00; cfg_a = 8'h00; cfg_b = 8'h00; force_flush = 1'b0;
    repeat (3) @(negedge clk);
    check(seg_attr === 32'h0, "R10 attr in reset", seg_attr, 32'h0);
    check({upd_strobe, flush_pulse, inval_req} === 10'h0, "R10 pulses in reset",
          {22'h0, upd_strobe, flush_pulse, inval_req}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    prev_attr = model(8'h00, 8'h00, 8'h00);
    check(seg_attr === prev_attr, "R1 R2 after reset", seg_attr, prev_attr);
  endtask

  task automatic t_ctrl_enables();
    step(8'h01, 8'h00, 8'h00, 1'b0);   // R1 seg 0 controlled, write internal
    step(8'h3F, 8'h00, 8'h00, 1'b0);   // R1 all low segs controlled
    step(8'hBF, 8'h00, 8'h00, 1'b0);   // R2 read internal
    step(8'hFF, 8'h00, 8'h00, 1'b0);   // R2 write blocked
    step(8'h40, 8'h00, 8'h00, 1'b0);   // R3 everything external
    step(8'h40, 8'h00, 8'h00, 1'b0);   // R6 unchanged -> no strobe
    check(upd_strobe === 8'h00, "R6 hold", {24'h0, upd_strobe}, 32'h0);
  endtask

  task automatic t_rom_mask();
    step(8'h40, 8'h40, 8'h00, 1'b0);   // R4 cfg_a[6] -> seg 0
    step(8'h40, 8'h80, 8'h00, 1'b0);   // R4 cfg_a[7] -> segs 4,5
    step(8'h40, 8'h00, 8'h04, 1'b0);   // R4 cfg_b[2] -> seg 1
    step(8'hC3, 8'hC0, 8'h04, 1'b0);   // R4 internal read masks rom bit
    check(seg_attr[1] === 1'b0, "R4 rom bit clear on internal", {31'h0, seg_attr[1]}, 32'h0);
  endtask

  task automatic t_invalidate();
    step(8'h80, 8'h00, 8'h00, 1'b0);   // R8 top segments read internal
    step(8'h00, 8'h00, 8'h00, 1'b0);   // R8 lost -> request
    check(inval_req === 1'b1, "R8 request", {31'h0, inval_req}, 32'h1);
    @(negedge clk);
    check(inval_req === 1'b0, "R8 single cycle", {31'h0, inval_req}, 32'h0);
  endtask

  task automatic t_flush();
    step(8'h00, 8'h00, 8'h00, 1'b1);   // R7 flush with no change
    check(upd_strobe === 8'hFF, "R7 all strobes", {24'h0, upd_strobe}, 32'hFF);
    @(negedge clk);
    check({flush_pulse, upd_strobe} === 9'h0, "R7 single cycle",
          {23'h0, flush_pulse, upd_strobe}, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ctrl_enables();
        t_rom_mask();
        t_invalidate();
        t_flush();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule